// File: doc/BRIEF.md
# Framer Periodic Event Status Register

This block collects the periodic framing events of a combined T1/E1 framer into one 8-bit sticky status register that a host can read. The framer supplies a one-cycle strobe at the start of each receive frame and each transmit frame, plus the current framing mode. The mode inputs are E1 versus T1, and in T1 the choice of D4 or ESF multiframe. A CRC-4 enable flag is also supplied.

Two identical cadence counters, one per direction, count frame strobes. They flag align-frame and multiframe boundaries at the period the mode calls for. A separate CRC-4 aligner supplies a multiframe strobe. Separate detectors supply level flags for all-zeros signaling, all-ones signaling and AIS-CI. These flags are gated by mode before they set their status bits.

The host reads the status register and clears it by writing ones. An adjacent interrupt-enable register masks the status bits onto a single active-high interrupt line.

Top module: `frame_event_status`

## Requirements
- R1: After reset the status register (address 0x1C) and the interrupt-enable register (address 0x1D) both read 0x00, and `irq_o` is low.
- R2: In E1 mode, status bit 0 (receive align) is set on the first receive strobe after reset or a mode change, and then on every second receive strobe. Bit 3 (transmit align) behaves the same way for transmit strobes. Neither bit is ever set in T1 mode.
- R3: In E1 mode, status bit 2 (receive multiframe) is set on the first receive strobe and then on every 16th one. Bit 4 (transmit multiframe) does the same for transmit strobes, independent of the CRC-4 enable.
- R4: In T1 mode, bits 2 and 4 are set every 12 frame strobes of their own direction when D4 is selected (`esf_i`=0), and every 24 when ESF is selected (`esf_i`=1).
- R5: Status bit 1 (receive CRC-4 multiframe) is set only in E1 mode. With `crc4_en_i`=1 it follows `crc4_mf_i`. With `crc4_en_i`=0 it follows the free-running 16-frame receive boundary and ignores `crc4_mf_i`.
- R6: In E1 mode, `sig_zero_i` sets bit 5 and `sig_ones_i` sets bit 6. In T1 mode both inputs are ignored.
- R7: In T1 mode, `ais_ci_i` sets bit 7. In E1 mode it is ignored.
- R8: Every status bit is sticky. A host write to address 0x1C clears each bit written as 1 and leaves the others unchanged. A set event in the same cycle as a clear leaves that bit set.
- R9: The interrupt-enable register is written and read at address 0x1D. `irq_o` is high exactly when some status bit and its enable bit are both 1.
- R10: Any change of `e1_i` or `esf_i` restarts both frame counters, so the next strobe after the change counts as a boundary. A strobe in the same cycle as the change is not counted.
- R11: A status bit becomes visible one clock after its event input is sampled. `rdata_o` reflects the addressed register combinationally while `rd_i` is high and is 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_frame_i | input | 1 | One-cycle strobe at start of each receive frame |
| tx_frame_i | input | 1 | One-cycle strobe at start of each transmit frame |
| e1_i | input | 1 | 1 = E1 framing, 0 = T1 framing |
| esf_i | input | 1 | T1 multiframe: 1 = ESF (24 frames), 0 = D4 (12 frames) |
| crc4_en_i | input | 1 | CRC-4 multiframing enabled (E1) |
| crc4_mf_i | input | 1 | CRC-4 multiframe boundary strobe from the aligner |
| sig_zero_i | input | 1 | Timeslot-16 all-zeros detected |
| sig_ones_i | input | 1 | Timeslot-16 all-ones detected |
| ais_ci_i | input | 1 | AIS-CI pattern detected |
| addr_i | input | 8 | Host register address |
| rd_i | input | 1 | Host read enable |
| wr_i | input | 1 | Host write enable |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| irq_o | output | 1 | Active-high masked interrupt |

## Verification
Each event input is sampled at a rising edge and shows up in the status register one clock later. Host writes and their interrupt effect take effect at the edge that samples them. Reads are combinational. The bench therefore drives every stimulus on a falling edge and holds it for one full cycle. It samples `rdata_o` and `irq_o` one time unit after the next falling edge, when every registered result of that stimulus has settled. For a mode change, the bench waits one idle cycle before the next strobe, so the restart cycle absorbs no strobe.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned ADDR_W = 8;

  localparam int unsigned B_RX_ALIGN = 0;
  localparam int unsigned B_RX_CRC4  = 1;
  localparam int unsigned B_RX_MF    = 2;
  localparam int unsigned B_TX_ALIGN = 3;
  localparam int unsigned B_TX_MF    = 4;
  localparam int unsigned B_SIG_ZERO = 5;
  localparam int unsigned B_SIG_ONES = 6;
  localparam int unsigned B_AIS_CI   = 7;

  typedef struct packed {
    logic e1;
    logic esf;
  } mode_t;
endpackage

// File: rtl/fes_cadence.sv
module fes_cadence #(
  parameter int unsigned E1_MF  = 16,
  parameter int unsigned D4_MF  = 12,
  parameter int unsigned ESF_MF = 24,
  parameter int unsigned E1_AF  = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           frame_i,
  input  fes_pkg::mode_t mode_i,
  output logic           align_o,
  output logic           mf_o
);
  localparam int unsigned MAX_MF = (E1_MF > D4_MF) ? ((E1_MF > ESF_MF) ? E1_MF : ESF_MF)
                                                   : ((D4_MF > ESF_MF) ? D4_MF : ESF_MF);
  localparam int unsigned CW = $clog2(MAX_MF + 1);

  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  modulus;
  fes_pkg::mode_t mode_q;
  logic           chg;

  assign chg = (mode_q != mode_i);

  always_comb begin
    if (mode_i.e1)       modulus = CW'(E1_MF);
    else if (mode_i.esf) modulus = CW'(ESF_MF);
    else                 modulus = CW'(D4_MF);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= '0;
    end else begin
      mode_q <= mode_i;
      if (chg)                       cnt_q <= '0;
      else if (frame_i)              cnt_q <= (cnt_q == modulus - CW'(1)) ? '0 : cnt_q + CW'(1);
    end
  end

  assign mf_o    = frame_i && !chg && (cnt_q == '0);
  assign align_o = frame_i && !chg && mode_i.e1 && ((cnt_q % CW'(E1_AF)) == '0);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg |-> (cnt_q < modulus)); // R4
  AST_MODE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> (cnt_q == '0)); // R10
  AST_T1_NO_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i.e1 |-> !align_o); // R2
endmodule

// File: rtl/fes_event_reg.sv
module fes_event_reg #(
  parameter int unsigned         W         = 8,
  parameter int unsigned         AW        = 8,
  parameter logic [AW-1:0]       STAT_ADDR = 8'h1C,
  parameter logic [AW-1:0]       IEN_ADDR  = 8'h1D
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  set_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic          irq_o
);
  logic [W-1:0] stat_q, ien_q, clr;
  logic         stat_sel, ien_sel;

  assign stat_sel = (addr_i == STAT_ADDR);
  assign ien_sel  = (addr_i == IEN_ADDR);
  assign clr      = (wr_i && stat_sel) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | set_i;
      if (wr_i && ien_sel) ien_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (stat_sel)     rdata_o = stat_q;
      else if (ien_sel) rdata_o = ien_q;
    end
  end

  assign irq_o = |(stat_q & ien_q);

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr)) == $past(stat_q & ~clr))); // R8
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(set_i)) == $past(set_i))); // R8
  AST_FULL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && stat_sel && (&wdata_i) && (set_i == '0)) |=> (stat_q == '0)); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o); // R9
endmodule

// File: rtl/frame_event_status.sv
module frame_event_status #(
  parameter int unsigned             E1_MF     = 16,
  parameter int unsigned             D4_MF     = 12,
  parameter int unsigned             ESF_MF    = 24,
  parameter int unsigned             E1_AF     = 2,
  parameter logic [fes_pkg::ADDR_W-1:0] STAT_ADDR = 8'h1C,
  parameter logic [fes_pkg::ADDR_W-1:0] IEN_ADDR  = 8'h1D
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rx_frame_i,
  input  logic                        tx_frame_i,
  input  logic                        e1_i,
  input  logic                        esf_i,
  input  logic                        crc4_en_i,
  input  logic                        crc4_mf_i,
  input  logic                        sig_zero_i,
  input  logic                        sig_ones_i,
  input  logic                        ais_ci_i,
  input  logic [fes_pkg::ADDR_W-1:0]  addr_i,
  input  logic                        rd_i,
  input  logic                        wr_i,
  input  logic [fes_pkg::STAT_W-1:0]  wdata_i,
  output logic [fes_pkg::STAT_W-1:0]  rdata_o,
  output logic                        irq_o
);
  import fes_pkg::*;

  localparam int unsigned SIDES = 2;  // 0 = receive, 1 = transmit

  mode_t             mode;
  logic [SIDES-1:0]  frame, align, mf;
  logic [STAT_W-1:0] set;

  assign mode.e1  = e1_i;
  assign mode.esf = esf_i;
  assign frame    = {tx_frame_i, rx_frame_i};

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    fes_cadence #(
      .E1_MF (E1_MF),
      .D4_MF (D4_MF),
      .ESF_MF(ESF_MF),
      .E1_AF (E1_AF)
    ) u_cad (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .frame_i(frame[g]),
      .mode_i (mode),
      .align_o(align[g]),
      .mf_o   (mf[g])
    );
  end

  always_comb begin
    set             = '0;
    set[B_RX_ALIGN] = align[0];
    set[B_TX_ALIGN] = align[1];
    set[B_RX_MF]    = mf[0];
    set[B_TX_MF]    = mf[1];
    // without CRC-4 the receive multiframe counter stands in as a free-running boundary
    set[B_RX_CRC4]  = e1_i && (crc4_en_i ? crc4_mf_i : mf[0]);
    set[B_SIG_ZERO] = e1_i && sig_zero_i;
    set[B_SIG_ONES] = e1_i && sig_ones_i;
    set[B_AIS_CI]   = !e1_i && ais_ci_i;
  end

  fes_event_reg #(
    .W        (STAT_W),
    .AW       (ADDR_W),
    .STAT_ADDR(STAT_ADDR),
    .IEN_ADDR (IEN_ADDR)
  ) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .addr_i (addr_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );

  AST_E1_ONLY_SIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !e1_i |-> !(set[B_SIG_ZERO] || set[B_SIG_ONES] || set[B_RX_CRC4])); // R6
  AST_T1_ONLY_AIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e1_i |-> !set[B_AIS_CI]); // R7
endmodule

// File: tb/frame_event_status_tb_top.sv
module frame_event_status_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] A_STAT = 8'h1C;
  localparam logic [7:0] A_IEN  = 8'h1D;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       rx_frame_i = 0, tx_frame_i = 0, e1_i = 0, esf_i = 0, crc4_en_i = 0, crc4_mf_i = 0;
  logic       sig_zero_i = 0, sig_ones_i = 0, ais_ci_i = 0;
  logic [7:0] addr_i = '0, wdata_i = '0, rdata_o;
  logic       rd_i = 0, wr_i = 0, irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  frame_event_status dut_i (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_reset(bit e1, bit esf, bit crc);
    @(negedge clk_i);
    rst_ni = 0; e1_i = e1; esf_i = esf; crc4_en_i = crc;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);  // absorb mode restart
  endtask

  task automatic frames(bit rx, bit tx, int n);
    for (int i = 0; i < n; i++) begin
      rx_frame_i = rx; tx_frame_i = tx;
      @(negedge clk_i);
      rx_frame_i = 0; tx_frame_i = 0;
    end
  endtask

  task automatic hwr(logic [7:0] a, logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1;
    @(negedge clk_i);
    wr_i = 0;
  endtask

  task automatic hrd(logic [7:0] a, output logic [7:0] d);
    addr_i = a; rd_i = 1;
    #1 d = rdata_o;
    rd_i = 0;
  endtask

  task automatic stat_is(string req, logic [7:0] exp);
    logic [7:0] d;
    hrd(A_STAT, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    @(negedge clk_i);
    rst_ni = 0;
    #1;
    stat_is("R1 status", 8'h00);
    hrd(A_IEN, d); chk("R1 ien", d, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
    rd_i = 0; chk("R11 rdata idle", rdata_o, 8'h00);
  endtask

  task automatic t_e1_align;
    do_reset(1, 0, 0);
    frames(1, 0, 1); stat_is("R2 rx first", 8'h07);
    hwr(A_STAT, 8'hFF);
    frames(1, 0, 1); stat_is("R2 rx odd", 8'h00);
    frames(1, 0, 1); stat_is("R2 rx even", 8'h01);
    hwr(A_STAT, 8'hFF);
    frames(0, 1, 1); stat_is("R2 tx first", 8'h18);
    hwr(A_STAT, 8'hFF);
    frames(0, 1, 1); stat_is("R2 tx odd", 8'h00);
  endtask

  task automatic t_e1_mf;
    logic [7:0] d;
    do_reset(1, 0, 0);
    frames(1, 1, 1); hwr(A_STAT, 8'hFF);
    frames(1, 1, 15);
    hrd(A_STAT, d); chk("R3 no mf before 16", d & 8'h16, 8'h00);
    hwr(A_STAT, 8'hFF);
    frames(1, 1, 1); stat_is("R3 mf at 16", 8'h1F);
  endtask

  task automatic t_t1_d4;
    do_reset(0, 0, 0);
    frames(1, 0, 1); stat_is("R4 d4 first", 8'h04);
    hwr(A_STAT, 8'hFF);
    frames(1, 0, 11); stat_is("R2 R4 d4 quiet", 8'h00);
    frames(1, 0, 1); stat_is("R4 d4 at 12", 8'h04);
  endtask

  task automatic t_t1_esf;
    do_reset(0, 1, 0);
    frames(0, 1, 1); stat_is("R4 esf first", 8'h10);
    hwr(A_STAT, 8'hFF);
    frames(0, 1, 23); stat_is("R4 esf quiet", 8'h00);
    frames(0, 1, 1); stat_is("R4 esf at 24", 8'h10);
  endtask

  task automatic t_crc4;
    do_reset(1, 0, 1);
    frames(1, 0, 1); stat_is("R5 crc4 on no free-run", 8'h05);
    hwr(A_STAT, 8'hFF);
    crc4_mf_i = 1; @(negedge clk_i); crc4_mf_i = 0;
    stat_is("R5 crc4 strobe", 8'h02);
    do_reset(1, 0, 0);
    crc4_mf_i = 1; @(negedge clk_i); crc4_mf_i = 0;
    stat_is("R5 strobe ignored crc4 off", 8'h00);
    do_reset(0, 0, 1);
    crc4_mf_i = 1; @(negedge clk_i); crc4_mf_i = 0;
    stat_is("R5 t1 ignored", 8'h00);
  endtask

  task automatic t_sig;
    do_reset(1, 0, 0);
    sig_zero_i = 1; @(negedge clk_i); sig_zero_i = 0;
    stat_is("R6 zeros", 8'h20);
    sig_ones_i = 1; @(negedge clk_i); sig_ones_i = 0;
    stat_is("R6 ones", 8'h60);
    ais_ci_i = 1; @(negedge clk_i); ais_ci_i = 0;
    stat_is("R7 ais ignored e1", 8'h60);
    do_reset(0, 0, 0);
    sig_zero_i = 1; sig_ones_i = 1; @(negedge clk_i); sig_zero_i = 0; sig_ones_i = 0;
    stat_is("R6 t1 ignored", 8'h00);
    ais_ci_i = 1; @(negedge clk_i); ais_ci_i = 0;
    stat_is("R7 ais t1", 8'h80);
  endtask

  task automatic t_sticky;
    do_reset(1, 0, 0);
    frames(1, 0, 1);
    hwr(A_STAT, 8'h01); stat_is("R8 partial clear", 8'h06);
    repeat (3) @(negedge clk_i);
    stat_is("R8 sticky", 8'h06);
    frames(1, 0, 1);
    // cnt now even: clear and align event collide
    addr_i = A_STAT; wdata_i = 8'h07; wr_i = 1; rx_frame_i = 1;
    @(negedge clk_i);
    wr_i = 0; rx_frame_i = 0;
    stat_is("R8 set wins", 8'h01);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    do_reset(1, 0, 0);
    hwr(A_IEN, 8'h04);
    hrd(A_IEN, d); chk("R9 ien readback", d, 8'h04);
    chk("R9 irq idle", {7'b0, irq_o}, 8'h00);
    frames(0, 1, 1); chk("R9 masked", {7'b0, irq_o}, 8'h00);
    frames(1, 0, 1); chk("R9 enabled", {7'b0, irq_o}, 8'h01);
    hwr(A_STAT, 8'h04); chk("R9 cleared", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_mode;
    do_reset(1, 0, 0);
    frames(1, 0, 3); hwr(A_STAT, 8'hFF);
    e1_i = 0; @(negedge clk_i);
    frames(1, 0, 1); stat_is("R10 t1 restart", 8'h04);
    hwr(A_STAT, 8'hFF);
    frames(1, 0, 2);
    esf_i = 1; @(negedge clk_i);
    frames(1, 0, 1); stat_is("R10 esf restart", 8'h04);
    hwr(A_STAT, 8'hFF);
    e1_i = 1; esf_i = 0; @(negedge clk_i);
    frames(1, 0, 1); stat_is("R10 e1 restart", 8'h07);
  endtask

  initial begin
    t_reset;
    t_e1_align;
    t_e1_mf;
    t_t1_d4;
    t_t1_esf;
    t_crc4;
    t_sig;
    t_sticky;
    t_irq;
    t_mode;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule